// File: doc/BRIEF.md
# Oscillator Alarm and Shutdown Supervisor

This block watches a bank of free-running oscillators that feed an entropy source. Each oscillator raises an alarm input whenever its own quality monitor flags a bad sample. The supervisor keeps an alarm counter for every oscillator. When an oscillator collects more alarms than a programmable threshold allows, the supervisor turns that oscillator off and records it in a stopped set.

A second shutdown is treated as an escalation. If an oscillator trips while another is already stopped, or if two trip in the same cycle, a sticky shutdown-overflow flag is raised. Software recovers by copying the stopped set into the detune register, clearing the mask and the stopped set, and then re-enabling every oscillator.

Software sees a small register slice with a single-cycle write port and a combinational read port. Offsets: 0x10 status, 0x1C alarm threshold, 0x20 enable, 0x24 detune, 0x28 alarm mask, 0x2C stopped set.

Top module: `osc_alarm_supervisor`

## Requirements
- R1: After reset the enable, detune, mask and stopped registers read 0, the status register reads 0, and the threshold (offset 0x1C, bits 7:0) reads 0xFF.
- R2: A write to 0x1C (bits 7:0), 0x20, 0x24, 0x28 or 0x2C is visible on the read port at the same offset on the next cycle. The enable register drives `osc_en_o` and the detune register drives `detune_o`.
- R3: An alarm is counted on each clock edge where the oscillator's alarm is high, its enable bit is 1 and its mask bit is 0. The counted alarm that takes the count past the threshold (alarm number threshold+1) sets the oscillator's stopped bit and clears its enable bit on that same edge.
- R4: Alarms from an oscillator whose mask bit is 1, or whose enable bit is 0, are ignored. They neither advance its count nor stop it.
- R5: A trip resets that oscillator's alarm count to zero. After re-enabling, threshold+1 fresh alarms are needed to stop it again.
- R6: A trip that occurs while another oscillator's stopped bit is already set, or two trips on the same edge, sets the shutdown-overflow flag. The flag is read as bit 1 of the status register (0x10) and drives `shutdown_ovf_o`.
- R7: The shutdown-overflow flag is sticky. It is cleared only by writing 1 to status bit 1; writing 0 there leaves it set.
- R8: A single trip while no oscillator is stopped does not set the shutdown-overflow flag.
- R9: The recovery sequence (write detune, write mask 0, write stopped 0, write enable all ones) leaves every oscillator enabled and the stopped set empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Write byte offset |
| reg_wdata_i | input | 32 | Write data |
| rd_addr_i | input | 8 | Read byte offset |
| rd_data_o | output | 32 | Read data (combinational) |
| alarm_i | input | NUM_OSC | Per-oscillator alarm, one count per high cycle |
| osc_en_o | output | NUM_OSC | Per-oscillator run enable |
| detune_o | output | NUM_OSC | Per-oscillator detune setting |
| stopped_o | output | NUM_OSC | Oscillators shut down by the supervisor |
| shutdown_ovf_o | output | 1 | Sticky shutdown-overflow flag |

## Verification
The assertions take for granted that `alarm_i` is synchronous to `clk` and that a register write and a trip may meet on one edge. In that case a trip overrides the written enable and stopped bits. The overflow assertions also assume software does not clear the flag in the cycle it rises. The stimulus meets these conditions by never writing while alarms are driven. It raises alarms only between writes, and it clears status only after the trips have settled. It still reaches single trips, trips on a stopped set, simultaneous trips and a zero threshold.

// File: rtl/osc_sup_pkg.sv
package osc_sup_pkg;
    localparam int REG_W  = 32;
    localparam int ADDR_W = 8;
    localparam int THR_W  = 8;

    localparam logic [ADDR_W-1:0] OFF_STATUS = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_THRESH = 8'h1C;
    localparam logic [ADDR_W-1:0] OFF_ENABLE = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_DETUNE = 8'h24;
    localparam logic [ADDR_W-1:0] OFF_MASK   = 8'h28;
    localparam logic [ADDR_W-1:0] OFF_STOP   = 8'h2C;

    localparam int STATUS_OVF_BIT = 1;
    localparam logic [THR_W-1:0] THRESH_RESET = '1;
endpackage

// File: rtl/osc_alarm_lane.sv
module osc_alarm_lane #(
    parameter int THR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_en,
    input  logic [THR_W-1:0] thresh,
    output logic             trip
);
    logic [THR_W-1:0] cnt_d, cnt_q;

    always_comb begin
        trip  = count_en && (cnt_q == thresh);
        cnt_d = cnt_q;
        if (trip)
            cnt_d = '0;
        else if (count_en)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R5: a trip leaves the count at zero
    p_trip_resets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trip |=> (cnt_q == '0));

    // R3: each counted alarm below the limit advances the count by one
    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (count_en && !trip) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/osc_trip_escalate.sv
module osc_trip_escalate #(
    parameter int NUM_OSC = 32
) (
    input  logic [NUM_OSC-1:0] trip,
    input  logic [NUM_OSC-1:0] stopped,
    output logic               ovf_event
);
    logic any_trip, multi_trip, any_stopped;

    always_comb begin
        any_trip    = |trip;
        multi_trip  = ($countones(trip) > 1);
        any_stopped = |stopped;
        ovf_event   = any_trip && (any_stopped || multi_trip);
    end
endmodule

// File: rtl/osc_alarm_supervisor.sv
module osc_alarm_supervisor
    import osc_sup_pkg::*;
#(
    parameter int NUM_OSC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic [REG_W-1:0]   reg_wdata_i,
    input  logic [ADDR_W-1:0]  rd_addr_i,
    output logic [REG_W-1:0]   rd_data_o,
    input  logic [NUM_OSC-1:0] alarm_i,
    output logic [NUM_OSC-1:0] osc_en_o,
    output logic [NUM_OSC-1:0] detune_o,
    output logic [NUM_OSC-1:0] stopped_o,
    output logic               shutdown_ovf_o
);
    typedef struct packed {
        logic [THR_W-1:0]   thresh;
        logic [NUM_OSC-1:0] en;
        logic [NUM_OSC-1:0] detune;
        logic [NUM_OSC-1:0] mask;
        logic [NUM_OSC-1:0] stop;
        logic               ovf;
    } sup_state_t;

    sup_state_t         s_d, s_q;
    logic [NUM_OSC-1:0] count_en;
    logic [NUM_OSC-1:0] trip;
    logic               ovf_event;
    logic               ovf_clear;

    assign count_en = alarm_i & s_q.en & ~s_q.mask;

    for (genvar g = 0; g < NUM_OSC; g++) begin : g_lane
        osc_alarm_lane #(.THR_W(THR_W)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .count_en (count_en[g]),
            .thresh   (s_q.thresh),
            .trip     (trip[g])
        );
    end

    osc_trip_escalate #(.NUM_OSC(NUM_OSC)) u_escalate (
        .trip      (trip),
        .stopped   (s_q.stop),
        .ovf_event (ovf_event)
    );

    assign ovf_clear = reg_wr_i && (reg_addr_i == OFF_STATUS)
                       && reg_wdata_i[STATUS_OVF_BIT];

    always_comb begin
        s_d = s_q;
        if (reg_wr_i) begin
            case (reg_addr_i)
                OFF_THRESH: s_d.thresh = reg_wdata_i[THR_W-1:0];
                OFF_ENABLE: s_d.en     = reg_wdata_i[NUM_OSC-1:0];
                OFF_DETUNE: s_d.detune = reg_wdata_i[NUM_OSC-1:0];
                OFF_MASK:   s_d.mask   = reg_wdata_i[NUM_OSC-1:0];
                OFF_STOP:   s_d.stop   = reg_wdata_i[NUM_OSC-1:0];
                default: ;
            endcase
        end
        if (ovf_clear) s_d.ovf = 1'b0;
        // trips win over a same-cycle write
        s_d.en   = s_d.en & ~trip;
        s_d.stop = s_d.stop | trip;
        if (ovf_event) s_d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.thresh <= THRESH_RESET;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        rd_data_o = '0;
        case (rd_addr_i)
            OFF_STATUS: rd_data_o[STATUS_OVF_BIT] = s_q.ovf;
            OFF_THRESH: rd_data_o = REG_W'(s_q.thresh);
            OFF_ENABLE: rd_data_o = REG_W'(s_q.en);
            OFF_DETUNE: rd_data_o = REG_W'(s_q.detune);
            OFF_MASK:   rd_data_o = REG_W'(s_q.mask);
            OFF_STOP:   rd_data_o = REG_W'(s_q.stop);
            default: ;
        endcase
    end

    assign osc_en_o       = s_q.en;
    assign detune_o       = s_q.detune;
    assign stopped_o      = s_q.stop;
    assign shutdown_ovf_o = s_q.ovf;

    // R3: a tripping oscillator ends up stopped and disabled
    p_trip_stops_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|trip) |=> (((s_q.stop & $past(trip)) == $past(trip))
                     && ((s_q.en & $past(trip)) == '0)));

    // R6: the overflow flag only rises after a trip
    p_ovf_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.ovf) |-> $past(|trip));

    // R7: the flag holds unless software writes 1 to its status bit
    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ovf && !ovf_clear) |=> s_q.ovf);

    // R8: a lone trip with nothing stopped does not raise the flag
    p_first_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.ovf && (s_q.stop == '0) && ($countones(trip) == 1)) |=> !s_q.ovf);
endmodule

// File: tb/osc_alarm_supervisor_test.sv
module osc_alarm_supervisor_test;
    localparam int N = 32;
    localparam int PIN_EN  = 256;
    localparam int PIN_DET = 257;
    localparam int PIN_STP = 258;
    localparam int PIN_OVF = 259;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr_i = 1'b0;
    logic [7:0]    reg_addr_i = '0;
    logic [31:0]   reg_wdata_i = '0;
    logic [7:0]    rd_addr_i = '0;
    logic [31:0]   rd_data_o;
    logic [N-1:0]  alarm_i = '0;
    logic [N-1:0]  osc_en_o, detune_o, stopped_o;
    logic          shutdown_ovf_o;

    osc_alarm_supervisor #(.NUM_OSC(N)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
        .reg_wdata_i(reg_wdata_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
        .alarm_i(alarm_i), .osc_en_o(osc_en_o), .detune_o(detune_o),
        .stopped_o(stopped_o), .shutdown_ovf_o(shutdown_ovf_o)
    );

    always #10 clk = ~clk;

    typedef struct {
        int          addr;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int pending = 0;
    int checks = 0;
    int fails = 0;
    bit done = 0;

    task automatic expect_item(input int addr, input logic [31:0] exp, input string tag);
        item_t it;
        it.addr = addr; it.exp = exp; it.tag = tag;
        q.push_back(it);
        pending++;
    endtask

    task automatic settle();
        wait (pending == 0);
    endtask

    // monitor: pops expected items and compares against the design
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                if (it.addr < 256) rd_addr_i = it.addr[7:0];
                #1;
                case (it.addr)
                    PIN_EN:  act = osc_en_o;
                    PIN_DET: act = detune_o;
                    PIN_STP: act = stopped_o;
                    PIN_OVF: act = {31'b0, shutdown_ovf_o};
                    default: act = rd_data_o;
                endcase
                checks++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s addr=%0h actual=%h expected=%h", it.tag, it.addr, act, it.exp);
                end
                pending--;
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        @(negedge clk);
        reg_wr_i = 1'b0;
    endtask

    task automatic pulse(input logic [N-1:0] v, input int n);
        @(negedge clk);
        alarm_i = v;
        repeat (n) @(negedge clk);
        alarm_i = '0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        expect_item(8'h20, 32'h0, "R1 enable");
        expect_item(8'h2C, 32'h0, "R1 stop");
        expect_item(8'h1C, 32'hFF, "R1 thresh");
        expect_item(8'h10, 32'h0, "R1 status");
        expect_item(PIN_EN, 32'h0, "R1 osc_en pin");
        settle();

        // R2 register access
        wr(8'h1C, 32'hFFFF_FF02);
        wr(8'h24, 32'hA5A5_0F0F);
        wr(8'h28, 32'h0000_0010);
        wr(8'h20, 32'hFFFF_FFFF);
        expect_item(8'h1C, 32'h02, "R2 thresh");
        expect_item(8'h24, 32'hA5A5_0F0F, "R2 detune");
        expect_item(PIN_DET, 32'hA5A5_0F0F, "R2 detune pin");
        expect_item(8'h28, 32'h10, "R2 mask");
        expect_item(PIN_EN, 32'hFFFF_FFFF, "R2 enable pin");
        settle();

        // R4 masked oscillator 4 ignored
        pulse(32'h10, 5);
        expect_item(8'h2C, 32'h0, "R4 masked stop");
        expect_item(PIN_EN, 32'hFFFF_FFFF, "R4 masked enable");
        settle();
        // R4 disabled oscillator 5 ignored
        wr(8'h20, 32'hFFFF_FFDF);
        pulse(32'h20, 5);
        expect_item(8'h2C, 32'h0, "R4 disabled stop");
        settle();
        wr(8'h20, 32'hFFFF_FFFF);
        pulse(32'h20, 2);
        expect_item(8'h2C, 32'h0, "R4 disabled alarms not counted");
        settle();

        // R3 threshold boundary on oscillator 0
        pulse(32'h1, 2);
        expect_item(8'h2C, 32'h0, "R3 at threshold no stop");
        settle();
        pulse(32'h1, 1);
        expect_item(8'h2C, 32'h1, "R3 stop set");
        expect_item(PIN_EN, 32'hFFFF_FFFE, "R3 enable cleared");
        expect_item(8'h10, 32'h0, "R8 first trip no overflow");
        settle();

        // R6 second trip while osc 0 stopped
        pulse(32'h2, 3);
        expect_item(8'h2C, 32'h3, "R6 stop set");
        expect_item(8'h10, 32'h2, "R6 status bit1");
        expect_item(PIN_OVF, 32'h1, "R6 overflow pin");
        settle();

        // R7 clear behaviour
        wr(8'h10, 32'h0);
        expect_item(8'h10, 32'h2, "R7 write 0 keeps flag");
        settle();
        wr(8'h10, 32'h2);
        expect_item(8'h10, 32'h0, "R7 write 1 clears");
        settle();

        // R9 recovery sequence
        wr(8'h24, 32'h3);
        wr(8'h28, 32'h0);
        wr(8'h2C, 32'h0);
        wr(8'h20, 32'hFFFF_FFFF);
        expect_item(PIN_EN, 32'hFFFF_FFFF, "R9 all enabled");
        expect_item(PIN_STP, 32'h0, "R9 stopped empty");
        expect_item(PIN_DET, 32'h3, "R9 detune copy");
        settle();

        // R5 counter restarted after the trip
        pulse(32'h1, 2);
        expect_item(8'h2C, 32'h0, "R5 fresh count below limit");
        settle();
        pulse(32'h1, 1);
        expect_item(8'h2C, 32'h1, "R5 retrip");
        expect_item(8'h10, 32'h0, "R8 lone trip quiet");
        settle();

        // R6 simultaneous trips with nothing stopped
        wr(8'h2C, 32'h0);
        wr(8'h20, 32'hFFFF_FFFF);
        pulse(32'hC, 3);
        expect_item(8'h2C, 32'hC, "R6 simultaneous stop");
        expect_item(8'h10, 32'h2, "R6 simultaneous overflow");
        settle();

        // R3 zero threshold: first alarm trips
        wr(8'h10, 32'h2);
        wr(8'h2C, 32'h0);
        wr(8'h20, 32'hFFFF_FFFF);
        wr(8'h1C, 32'h0);
        pulse(32'h80, 1);
        expect_item(8'h2C, 32'h80, "R3 zero threshold");
        expect_item(PIN_EN, 32'hFFFF_FF7F, "R3 zero threshold enable");
        settle();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule